// File: doc/BRIEF.md
# Reset Source Controller

This block gathers every reason a chip may have to reset itself and turns them into one stretched, active-low system reset. Six request lines arrive from the pad, the watchdog, the clock generator (lock lost, reference clock lost), the supply monitor and a software register bit. The power-on input acts directly and asynchronously. Once the last request has gone away the reset is held for a further programmable number of cycles, 512 by default, so that downstream logic sees a clean, long pulse.

While it does this, the controller records which requests were active during the most recent reset in a status register that software reads after boot. A small register port also lets firmware start a reset of its own, drive the board-level reset output at any time, and choose whether a low-supply event resets the chip or only raises an interrupt.

The register port is a single-cycle write strobe with a one-bit address and a combinational read. Address 0 is the control register and address 1 is the status register.

Top module: `rstsrc_ctrl`

## Requirements
- R1: Each request (ext_req, wdog_req, lol_req, loc_req, lvd_det when reset mode is active, control bit 0) drives sys_rst_n low. The four pin requests and lvd_det each pass through two flip-flops before they act.
- R2: sys_rst_n stays low until exactly STRETCH (512) cycles with no active request have elapsed. For a pin request dropped just before a clock edge, sys_rst_n is first seen high after the 514th rising edge, counting that edge as the first.
- R3: The status register (address 1) holds the cause flags: bit 0 pin, bit 1 power-on, bit 2 watchdog, bit 3 lock lost, bit 4 clock lost, bit 5 software, bit 6 low supply. On entry to a reset it is replaced by the requests active at that moment, and further requests arriving during the same reset are added.
- R4: por_n low acts asynchronously and forces sys_rst_n and ext_rst_out_n low. It sets the status to 0x02 only and returns the control register to 0x0C. Requests that arrive during the power-on sequence are not recorded.
- R5: Writing 1 to control bit 0 starts a software reset, which sets status bit 5. The bit reads back 0 once the reset has begun.
- R6: Control bit 1 drives ext_rst_out_n low whether or not the chip is in reset. ext_rst_out_n is also low throughout every system reset. Bit 1 keeps its value through every reset except power-on.
- R7: Control bit 2 enables the low-supply function and control bit 3 selects its mode (1 = reset, 0 = interrupt). Both return to 1 on every reset. With bit 2 at 0, lvd_det has no effect on sys_rst_n, lvd_irq or the status register.
- R8: In interrupt mode, lvd_det sets status bit 7 and lvd_irq and does not reset the chip. Writing 1 to status bit 7 clears the flag, but a still-active lvd_det wins over the clear.
- R9: Outside reset the cause flags do not change. Writes to status bits 6..0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_req | input | 1 | Reset request from the board pin, active high |
| wdog_req | input | 1 | Watchdog expiry request |
| lol_req | input | 1 | Clock generator lost lock |
| loc_req | input | 1 | Clock generator lost reference clock |
| lvd_det | input | 1 | Low-supply detector output |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control, 1 = status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| sys_rst_n | output | 1 | Stretched system reset, active low |
| ext_rst_out_n | output | 1 | Board reset output, active low |
| lvd_irq | output | 1 | Low-supply interrupt |

## Verification
On every cycle, the assertions check several properties. Any active request must pull the reset low on the next edge. The reset may only rise after exactly the stretch length of quiet cycles, as measured by an independent counter. A power-on cause must never be mixed with others. The software request must be clear one cycle into any reset. The flags must hold still while the chip runs. Other behaviour can only be shown by the bench's scenarios: which flag combination each source mix leaves behind, the exact release latency seen from the pins, the board output surviving a watchdog reset and being lost on power-on, and the low-supply interrupt with its set-wins-over-clear rule.

// File: rtl/rstsrc_pkg.sv
package rstsrc_pkg;
  localparam int NUM_SRC = 7;
  localparam int DATA_W  = 8;
  localparam int NUM_PIN = 5;

  // cause flag positions (status register, software visible)
  localparam int CAUSE_EXT  = 0;
  localparam int CAUSE_POR  = 1;
  localparam int CAUSE_WDOG = 2;
  localparam int CAUSE_LOL  = 3;
  localparam int CAUSE_LOC  = 4;
  localparam int CAUSE_SW   = 5;
  localparam int CAUSE_LVD  = 6;
  localparam int STAT_IRQ   = 7;

  // control register bit positions
  localparam int CTL_SWREQ  = 0;
  localparam int CTL_EXTDRV = 1;
  localparam int CTL_LVDEN  = 2;
  localparam int CTL_LVDRST = 3;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  typedef logic [NUM_SRC-1:0] cause_t;

  localparam cause_t POR_ONLY = cause_t'(1) << CAUSE_POR;
endpackage

// File: rtl/rstsrc_sync.sv
module rstsrc_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/rstsrc_seq.sv
module rstsrc_seq
  import rstsrc_pkg::*;
#(
  parameter int STRETCH = 512
) (
  input  logic   clk,
  input  logic   rst_n,
  input  cause_t src,
  output logic   in_rst,
  output cause_t cause
);
  localparam int CNT_W = (STRETCH > 1) ? $clog2(STRETCH) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STRETCH - 1);

  logic             any_src;
  logic             in_rst_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  cause_t           cause_d;

  assign any_src = |src;

  always_comb begin
    in_rst_d = in_rst;
    cnt_d    = cnt_q;
    cause_d  = cause;
    if (any_src) begin
      in_rst_d = 1'b1;
      cnt_d    = '0;
      if (!in_rst) begin
        cause_d = src;
      end else if (!cause[CAUSE_POR]) begin
        cause_d = cause | src;
      end
    end else if (in_rst) begin
      if (cnt_q == CNT_LAST) begin
        in_rst_d = 1'b0;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_rst <= 1'b1;
      cnt_q  <= '0;
      cause  <= POR_ONLY;
    end else begin
      in_rst <= in_rst_d;
      cnt_q  <= cnt_d;
      cause  <= cause_d;
    end
  end
endmodule

// File: rtl/rstsrc_regs.sv
module rstsrc_regs
  import rstsrc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_rst,
  input  logic              lvd_level,
  input  cause_t            cause,
  input  logic              wr,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              sw_req,
  output logic              ext_drive,
  output logic              lvd_en,
  output logic              lvd_rst_mode,
  output logic              lvd_irq
);
  logic wr_ctrl, wr_stat;
  logic sw_req_d, ext_drive_d, lvd_en_d, lvd_rst_mode_d, lvd_irq_d;
  logic [DATA_W-1:0] wdata_unused;

  assign wr_ctrl      = wr && (addr == ADDR_CTRL);
  assign wr_stat      = wr && (addr == ADDR_STAT);
  assign wdata_unused = wdata;

  always_comb begin
    ext_drive_d    = wr_ctrl ? wdata[CTL_EXTDRV] : ext_drive;
    sw_req_d       = sw_req;
    lvd_en_d       = lvd_en;
    lvd_rst_mode_d = lvd_rst_mode;
    lvd_irq_d      = lvd_irq;
    if (in_rst) begin
      sw_req_d       = 1'b0;
      lvd_en_d       = 1'b1;
      lvd_rst_mode_d = 1'b1;
      lvd_irq_d      = 1'b0;
    end else begin
      if (wr_ctrl) begin
        sw_req_d       = wdata[CTL_SWREQ];
        lvd_en_d       = wdata[CTL_LVDEN];
        lvd_rst_mode_d = wdata[CTL_LVDRST];
      end
      if (lvd_en && !lvd_rst_mode && lvd_level) begin
        lvd_irq_d = 1'b1;
      end else if (wr_stat && wdata[STAT_IRQ]) begin
        lvd_irq_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_req       <= 1'b0;
      ext_drive    <= 1'b0;
      lvd_en       <= 1'b1;
      lvd_rst_mode <= 1'b1;
      lvd_irq      <= 1'b0;
    end else begin
      sw_req       <= sw_req_d;
      ext_drive    <= ext_drive_d;
      lvd_en       <= lvd_en_d;
      lvd_rst_mode <= lvd_rst_mode_d;
      lvd_irq      <= lvd_irq_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_CTRL) begin
      rdata[CTL_SWREQ]  = sw_req;
      rdata[CTL_EXTDRV] = ext_drive;
      rdata[CTL_LVDEN]  = lvd_en;
      rdata[CTL_LVDRST] = lvd_rst_mode;
    end else begin
      rdata[NUM_SRC-1:0] = cause;
      rdata[STAT_IRQ]    = lvd_irq;
    end
  end
endmodule

// File: rtl/rstsrc_ctrl.sv
module rstsrc_ctrl
  import rstsrc_pkg::*;
#(
  parameter int STRETCH = 512
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              ext_req,
  input  logic              wdog_req,
  input  logic              lol_req,
  input  logic              loc_req,
  input  logic              lvd_det,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              sys_rst_n,
  output logic              ext_rst_out_n,
  output logic              lvd_irq
);
  logic               por_s1, rst_n_sync;
  logic [NUM_PIN-1:0] pin_raw, pin_sync;
  cause_t             src, cause;
  logic               in_rst, sw_req, ext_drive, lvd_en, lvd_rst_mode;

  // power-on: asserts asynchronously, releases on a clock edge
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      por_s1     <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      por_s1     <= 1'b1;
      rst_n_sync <= por_s1;
    end
  end

  assign pin_raw = {lvd_det, loc_req, lol_req, wdog_req, ext_req};

  rstsrc_sync #(.WIDTH(NUM_PIN)) u_sync (
    .clk  (clk),
    .rst_n(rst_n_sync),
    .d    (pin_raw),
    .q    (pin_sync)
  );

  always_comb begin
    src            = '0;
    src[CAUSE_EXT]  = pin_sync[0];
    src[CAUSE_WDOG] = pin_sync[1];
    src[CAUSE_LOL]  = pin_sync[2];
    src[CAUSE_LOC]  = pin_sync[3];
    src[CAUSE_SW]   = sw_req;
    src[CAUSE_LVD]  = pin_sync[4] && lvd_en && lvd_rst_mode;
  end

  rstsrc_seq #(.STRETCH(STRETCH)) u_seq (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .src   (src),
    .in_rst(in_rst),
    .cause (cause)
  );

  rstsrc_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .in_rst      (in_rst),
    .lvd_level   (pin_sync[4]),
    .cause       (cause),
    .wr          (reg_wr),
    .addr        (reg_addr),
    .wdata       (reg_wdata),
    .rdata       (reg_rdata),
    .sw_req      (sw_req),
    .ext_drive   (ext_drive),
    .lvd_en      (lvd_en),
    .lvd_rst_mode(lvd_rst_mode),
    .lvd_irq     (lvd_irq)
  );

  assign sys_rst_n     = !in_rst;
  assign ext_rst_out_n = !(in_rst || ext_drive);
endmodule

// File: rtl/rstsrc_checker.sv
module rstsrc_checker
  import rstsrc_pkg::*;
#(
  parameter int STRETCH = 512
) (
  input logic   clk,
  input logic   rst_n,
  input cause_t src,
  input logic   sys_rst_n,
  input logic   sw_req,
  input cause_t cause
);
  localparam int QW = $clog2(STRETCH + 1) + 1;

  logic [QW-1:0] quiet_q;

  // independent count of request-free cycles spent in reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_q <= '0;
    end else if (|src) begin
      quiet_q <= '0;
    end else if (!sys_rst_n) begin
      quiet_q <= quiet_q + 1'b1;
    end else begin
      quiet_q <= '0;
    end
  end

  AST_SRC_HOLDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (|src) |=> !sys_rst_n); // R1
  AST_STRETCH_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n) |-> (quiet_q == QW'(STRETCH))); // R2
  AST_POR_FLAG_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    cause[CAUSE_POR] |-> (cause == POR_ONLY)); // R4
  AST_SWREQ_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!sys_rst_n) |-> !sw_req); // R5
  AST_CAUSE_STABLE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_n && $past(sys_rst_n)) |-> $stable(cause)); // R9
endmodule

bind rstsrc_ctrl rstsrc_checker #(.STRETCH(STRETCH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_sync),
  .src      (src),
  .sys_rst_n(sys_rst_n),
  .sw_req   (sw_req),
  .cause    (cause)
);

// File: tb/rstsrc_ctrl_bench.sv
`timescale 1ns/1ps
module rstsrc_ctrl_bench;
  localparam int STRETCH = 512;
  localparam int REL = STRETCH + 2;   // edges from stimulus to visible release
  localparam int NVEC = 7;
  // {mask[4:0] = lvd,loc,lol,wdog,ext ; expected status}
  localparam logic [12:0] VEC [NVEC] = '{
    {5'b00001, 8'h01}, {5'b00010, 8'h04}, {5'b00100, 8'h08},
    {5'b01000, 8'h10}, {5'b10000, 8'h40}, {5'b00011, 8'h05},
    {5'b11100, 8'h58}
  };

  logic       clk = 1'b0;
  logic       por_n, ext_req, wdog_req, lol_req, loc_req, lvd_det;
  logic       reg_wr, reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       sys_rst_n, ext_rst_out_n, lvd_irq;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2 clk = ~clk;

  rstsrc_ctrl #(.STRETCH(STRETCH)) u_rstsrc_ctrl (
    .clk(clk), .por_n(por_n), .ext_req(ext_req), .wdog_req(wdog_req),
    .lol_req(lol_req), .loc_req(loc_req), .lvd_det(lvd_det),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sys_rst_n(sys_rst_n),
    .ext_rst_out_n(ext_rst_out_n), .lvd_irq(lvd_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  // counts falling edges until sys_rst_n is seen high after having been low
  task automatic wait_release(output int n);
    logic seen_low;
    seen_low = !sys_rst_n;
    n = 0;
    while (n < 4000) begin
      @(negedge clk);
      n++;
      if (!sys_rst_n) seen_low = 1'b1;
      else if (seen_low) break;
    end
  endtask

  task automatic set_pins(input logic [4:0] m);
    {lvd_det, loc_req, lol_req, wdog_req, ext_req} = m;
  endtask

  task automatic pin_reset(input logic [4:0] m, input logic [7:0] exp_stat,
                           input string tag);
    int n;
    logic [7:0] d;
    @(negedge clk);
    set_pins(m);
    repeat (4) @(negedge clk);
    chk({tag, " sys_rst_n low during request"}, sys_rst_n, 0);
    chk({tag, " ext_rst_out_n low during reset"}, ext_rst_out_n, 0);
    set_pins(5'b0);
    wait_release(n);
    chk({tag, " release latency"}, n, REL);
    rd(1'b1, d);
    chk({tag, " cause flags"}, d, exp_stat);
  endtask

  task automatic power_on();
    int n;
    @(negedge clk);
    por_n = 1'b0;
    #1;
    chk("R4 sys_rst_n async low", sys_rst_n, 0);
    chk("R4 ext_rst_out_n low", ext_rst_out_n, 0);
    @(negedge clk);
    por_n = 1'b1;
    wait_release(n);
    chk("R2 R4 power-on release latency", n, REL);
  endtask

  initial begin
    logic [7:0] d;
    int n, lows;
    por_n = 1'b0; set_pins(5'b0);
    reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = 8'h00;
    repeat (3) @(negedge clk);

    // power-on state
    power_on();
    rd(1'b1, d); chk("R4 status after power-on", d, 8'h02);
    rd(1'b0, d); chk("R4 R7 control after power-on", d, 8'h0C);
    chk("R6 ext_rst_out_n high after power-on", ext_rst_out_n, 1);

    // table of pin sources and resulting cause flags (R1 R2 R3)
    for (int i = 0; i < NVEC; i++) begin
      pin_reset(VEC[i][12:8], VEC[i][7:0], $sformatf("R1 R3 vec%0d", i));
    end

    // software reset (R5)
    wr(1'b0, 8'h0D);
    chk("R5 no reset before request acts", sys_rst_n, 1);
    wait_release(n);
    chk("R5 R2 software reset latency", n, REL);
    rd(1'b1, d); chk("R5 cause is software only", d, 8'h20);
    rd(1'b0, d); chk("R5 request bit self-cleared", d, 8'h0C);

    // board output driven by software, survives watchdog reset (R6)
    wr(1'b0, 8'h0E);
    chk("R6 ext_rst_out_n driven while running", ext_rst_out_n, 0);
    chk("R6 chip not reset by drive bit", sys_rst_n, 1);
    pin_reset(5'b00010, 8'h04, "R6 wdog");
    rd(1'b0, d); chk("R6 drive bit kept through reset", d, 8'h0E);
    chk("R6 ext_rst_out_n still driven", ext_rst_out_n, 0);
    wr(1'b0, 8'h0C);
    chk("R6 ext_rst_out_n released", ext_rst_out_n, 1);
    wr(1'b0, 8'h0E);
    power_on();
    rd(1'b0, d); chk("R6 R4 drive bit cleared by power-on", d, 8'h0C);
    chk("R6 ext_rst_out_n high after power-on", ext_rst_out_n, 1);

    // request during power-on stretch not recorded (R4)
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    repeat (10) @(negedge clk);
    set_pins(5'b00100);
    repeat (4) @(negedge clk);
    set_pins(5'b0);
    wait_release(n);
    rd(1'b1, d); chk("R4 cause stays power-on only", d, 8'h02);

    // low supply in interrupt mode (R8)
    wr(1'b0, 8'h04);
    @(negedge clk); lvd_det = 1'b1;
    lows = 0;
    repeat (4) begin
      @(negedge clk);
      if (!sys_rst_n) lows++;
    end
    chk("R8 lvd_irq raised", lvd_irq, 1);
    rd(1'b1, d); chk("R8 status bit 7 set", d, 8'h82);
    wr(1'b1, 8'h80);
    if (!sys_rst_n) lows++;
    chk("R8 set wins over clear", lvd_irq, 1);
    @(negedge clk); lvd_det = 1'b0;
    repeat (4) @(negedge clk);
    wr(1'b1, 8'h80);
    chk("R8 write one clears flag", lvd_irq, 0);
    chk("R8 no reset in interrupt mode", lows, 0);

    // low supply disabled (R7)
    wr(1'b0, 8'h00);
    @(negedge clk); lvd_det = 1'b1;
    lows = 0;
    repeat (10) begin
      @(negedge clk);
      if (!sys_rst_n) lows++;
    end
    chk("R7 disabled: no reset", lows, 0);
    chk("R7 disabled: no interrupt", lvd_irq, 0);
    rd(1'b1, d); chk("R7 disabled: status unchanged", d, 8'h02);
    @(negedge clk); lvd_det = 1'b0;
    repeat (3) @(negedge clk);

    // cause flags are read-only (R9)
    wr(1'b1, 8'h7F);
    rd(1'b1, d); chk("R9 status ignores writes", d, 8'h02);
    repeat (20) @(negedge clk);
    rd(1'b1, d); chk("R9 status stable while running", d, 8'h02);

    summary();
  end
endmodule